// File: doc/BRIEF.md
# Gated PRBS Bit-Error Detector

This block checks a recovered serial bit stream against a pseudo-random binary sequence of one of four lengths. It takes one bit per clock, qualified by a valid flag. No seed or alignment hint is needed. The detector fills its own reference history from the arriving bits and then looks for a long run of agreeing bits before it declares sync. If the run it finds consists entirely of disagreeing bits, it takes the stream to be the inverted pattern. It then locks with a polarity flag set and compares against the complement from then on.

While locked, the reference runs free, so line errors do not disturb it. Each compared bit advances a measurement gate whose length is a number of compared bits. When the gate completes, the absolute count of errored bits and the count of compared bits are captured into result registers, and a one-cycle done pulse marks them as fresh. Downstream logic or software divides the two counts to get the error ratio. A burst of errors in a short window drops sync, and acquisition starts again. Bits that arrive while the detector is out of sync are never counted.

Top module: `prbs_err_detector`

## Requirements
- R1: After reset, locked, inverted and gate_done are low, and err_count and bit_count are zero.
- R2: prbs_sel picks the pattern order. The code 0 gives x^7+x^6+1, 1 gives x^15+x^14+1, 2 gives x^23+x^18+1 and 3 gives x^31+x^28+1. A clean stream of each order is measured with zero errors.
- R3: On a clean stream, locked rises right after the valid bit numbered k+64 since reset or loss of sync, where k is the order. The first k bits seed the reference, and the next 64 must all agree with its prediction.
- R4: When the 64 checked bits all disagree, locked rises together with inverted, and later bits are compared against the complement of the reference. inverted is only ever high while locked is high.
- R5: Only valid bits seen while locked are compared. Each one adds one to the bit count, and each one that differs from the expected bit adds one to the error count.
- R6: While locked, 16 errors within a 256-bit window are tolerated. The 17th error in the same window drops locked right after that bit, clears inverted, and restarts acquisition. Windows start at lock and repeat every 256 compared bits.
- R7: When the compared-bit count within the gate reaches gate_len, the counts including that bit move into err_count and bit_count, gate_done is high for that one cycle, and the running counts restart at zero. The result outputs change at no other time.
- R8: The running error and bit counts saturate at their all-ones value instead of wrapping.
- R9: A cycle with bit_valid low changes no output and no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| prbs_sel | input | 2 | Pattern order select (0:7, 1:15, 2:23, 3:31) |
| gate_len | input | GATE_W | Gate length in compared bits |
| bit_valid | input | 1 | bit_in carries a received bit this cycle |
| bit_in | input | 1 | Received data bit |
| locked | output | 1 | Detector is in sync and comparing |
| inverted | output | 1 | Stream was acquired with inverted polarity |
| gate_done | output | 1 | One-cycle pulse: new results captured |
| err_count | output | CNT_W | Errored bits counted in the last gate |
| bit_count | output | CNT_W | Compared bits counted in the last gate |

## Verification
The assertions assume that prbs_sel and gate_len stay constant during a measurement, because changing the order or the gate mid-run changes what counts as a match and as a complete gate. The assertions also assume that bit_valid and bit_in carry known values on every clock after reset. The stimulus changes the selection and the gate length only while reset is held, and it drives every input on every cycle. Random gaps in bit_valid carry random data bits, which exercises the rule that an idle cycle has no effect.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    // Acquisition state of the detector
    typedef enum logic [1:0] {
        MODE_FILL  = 2'd0,
        MODE_HUNT  = 2'd1,
        MODE_TRACK = 2'd2
    } sync_mode_e;

    // Reference history depth: enough for the longest order
    localparam int HIST_W = 31;

    function automatic int unsigned prbs_order(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7;
            2'd1:    return 15;
            2'd2:    return 23;
            default: return 31;
        endcase
    endfunction

endpackage

// File: rtl/prbs_history.sv
// Shift history of the last HIST_W stream bits and the predicted next bit
module prbs_history
    import prbs_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       shift_bit,
    input  logic [1:0] sel,
    output logic       pred
);

    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // Bit index i holds the bit received i+1 bit times ago
    always_comb begin
        case (sel)
            2'd0:    pred = hist_q[6]  ^ hist_q[5];
            2'd1:    pred = hist_q[14] ^ hist_q[13];
            2'd2:    pred = hist_q[22] ^ hist_q[17];
            default: pred = hist_q[30] ^ hist_q[27];
        endcase
    end

endmodule

// File: rtl/loss_monitor.sv
// Block-window error density monitor used to detect loss of sync
module loss_monitor #(
    parameter int WIN = 256,
    parameter int THR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic err,
    output logic drop
);

    localparam int WC_W = $clog2(WIN);
    localparam int EC_W = $clog2(THR + 2);

    typedef struct packed {
        logic [WC_W-1:0] pos;
        logic [EC_W-1:0] errs;
    } win_t;

    win_t w_d, w_q;
    logic [EC_W-1:0] errs_next;

    assign errs_next = w_q.errs + EC_W'(err);
    assign drop      = step && (errs_next > EC_W'(THR));

    always_comb begin
        w_d = w_q;
        if (clear || drop) begin
            w_d = '0;
        end else if (step) begin
            if (w_q.pos == WC_W'(WIN - 1)) begin
                w_d = '0;
            end else begin
                w_d.pos  = w_q.pos + WC_W'(1);
                w_d.errs = errs_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

endmodule

// File: rtl/gate_meter.sv
// Gate counter with saturating accumulators and captured results
module gate_meter #(
    parameter int CNT_W  = 32,
    parameter int GATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              err,
    input  logic [GATE_W-1:0] gate_len,
    output logic              done,
    output logic [CNT_W-1:0]  err_res,
    output logic [CNT_W-1:0]  bit_res
);

    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic [GATE_W-1:0] pos;
        logic [CNT_W-1:0]  errs;
        logic [CNT_W-1:0]  bits;
        logic [CNT_W-1:0]  err_res;
        logic [CNT_W-1:0]  bit_res;
        logic              done;
    } gate_t;

    gate_t g_d, g_q;
    logic [CNT_W-1:0] errs_n, bits_n;
    logic             gate_end;

    assign errs_n   = (!err || g_q.errs == SAT) ? g_q.errs : g_q.errs + CNT_W'(1);
    assign bits_n   = (g_q.bits == SAT) ? SAT : g_q.bits + CNT_W'(1);
    assign gate_end = ((GATE_W+1)'(g_q.pos) + (GATE_W+1)'(1)) >= (GATE_W+1)'(gate_len);

    always_comb begin
        g_d      = g_q;
        g_d.done = 1'b0;
        if (step) begin
            if (gate_end) begin
                g_d.err_res = errs_n;
                g_d.bit_res = bits_n;
                g_d.done    = 1'b1;
                g_d.pos     = '0;
                g_d.errs    = '0;
                g_d.bits    = '0;
            end else begin
                g_d.pos  = g_q.pos + GATE_W'(1);
                g_d.errs = errs_n;
                g_d.bits = bits_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign done    = g_q.done;
    assign err_res = g_q.err_res;
    assign bit_res = g_q.bit_res;

endmodule

// File: rtl/prbs_err_detector.sv
module prbs_err_detector
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int GATE_W   = 32,
    parameter int SYNC_RUN = 64,
    parameter int LOSS_WIN = 256,
    parameter int LOSS_THR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        prbs_sel,
    input  logic [GATE_W-1:0] gate_len,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              locked,
    output logic              inverted,
    output logic              gate_done,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  bit_count
);

    localparam int RUN_W = $clog2(SYNC_RUN + HIST_W + 1);

    typedef struct packed {
        sync_mode_e       mode;
        logic [RUN_W-1:0] run;
        logic             run_bad;
        logic             inv;
    } acq_t;

    acq_t st_d, st_q;

    logic             pred_bit, exp_bit, fed_bit, miss, trk_step, drop;
    logic [RUN_W-1:0] order_w;

    assign order_w  = RUN_W'(prbs_order(prbs_sel));
    assign exp_bit  = pred_bit ^ st_q.inv;
    assign miss     = bit_in ^ exp_bit;
    assign trk_step = bit_valid && (st_q.mode == MODE_TRACK);
    // Acquiring: history follows the line; tracking: it runs free
    assign fed_bit  = (st_q.mode == MODE_TRACK) ? exp_bit : bit_in;

    prbs_history u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (bit_valid),
        .shift_bit (fed_bit),
        .sel       (prbs_sel),
        .pred      (pred_bit)
    );

    loss_monitor #(
        .WIN (LOSS_WIN),
        .THR (LOSS_THR)
    ) u_loss (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_q.mode != MODE_TRACK),
        .step  (trk_step),
        .err   (miss),
        .drop  (drop)
    );

    gate_meter #(
        .CNT_W  (CNT_W),
        .GATE_W (GATE_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (trk_step),
        .err      (miss),
        .gate_len (gate_len),
        .done     (gate_done),
        .err_res  (err_count),
        .bit_res  (bit_count)
    );

    always_comb begin
        st_d = st_q;
        if (bit_valid) begin
            unique case (st_q.mode)
                MODE_FILL: begin
                    st_d.run = st_q.run + RUN_W'(1);
                    if (st_q.run + RUN_W'(1) == order_w) begin
                        st_d.mode = MODE_HUNT;
                        st_d.run  = '0;
                    end
                end
                MODE_HUNT: begin
                    if (st_q.run == '0 || miss == st_q.run_bad) begin
                        st_d.run     = st_q.run + RUN_W'(1);
                        st_d.run_bad = miss;
                        if (st_q.run + RUN_W'(1) == RUN_W'(SYNC_RUN)) begin
                            st_d.mode = MODE_TRACK;
                            st_d.inv  = miss;
                            st_d.run  = '0;
                        end
                    end else begin
                        st_d.run     = RUN_W'(1);
                        st_d.run_bad = miss;
                    end
                end
                default: begin
                    if (drop) begin
                        st_d.mode    = MODE_FILL;
                        st_d.run     = '0;
                        st_d.run_bad = 1'b0;
                        st_d.inv     = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{MODE_FILL, '0, 1'b0, 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked   = (st_q.mode == MODE_TRACK);
    assign inverted = st_q.inv;

endmodule

// File: rtl/prbs_err_detector_chk.sv
module prbs_err_detector_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             locked,
    input logic             inverted,
    input logic             gate_done,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] bit_count
);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(locked) && $stable(inverted) && $stable(err_count)
                       && $stable(bit_count) && !gate_done);

    assert_inv_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inverted |-> locked);

    assert_lock_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_valid));

    assert_loss_on_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bit_valid) && $past(locked));

    assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |-> $past(bit_valid) && $past(locked) && bit_count != '0);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_done |-> $stable(err_count) && $stable(bit_count));

    assert_err_le_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_count <= bit_count);

endmodule

bind prbs_err_detector prbs_err_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .locked    (locked),
    .inverted  (inverted),
    .gate_done (gate_done),
    .err_count (err_count),
    .bit_count (bit_count)
);

// File: tb/prbs_err_detector_bench.sv
`timescale 1ns/1ps
module prbs_err_detector_bench;

    localparam int CNT_W  = 8;
    localparam int GATE_W = 16;
    localparam int SAT    = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        prbs_sel = 2'd0;
    logic [GATE_W-1:0] gate_len = 16'd200;
    logic              bit_valid = 1'b0;
    logic              bit_in = 1'b0;
    logic              locked, inverted, gate_done;
    logic [CNT_W-1:0]  err_count, bit_count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lock_at = -1;

    always #2.5 clk = ~clk;

    prbs_err_detector #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_prbs_err_detector (
        .clk(clk), .rst_n(rst_n), .prbs_sel(prbs_sel), .gate_len(gate_len),
        .bit_valid(bit_valid), .bit_in(bit_in), .locked(locked), .inverted(inverted),
        .gate_done(gate_done), .err_count(err_count), .bit_count(bit_count));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int ord(input int s);
        case (s) 0: return 7; 1: return 15; 2: return 23; default: return 31; endcase
    endfunction

    function automatic int tap2(input int s);
        case (s) 0: return 6; 1: return 14; 2: return 18; default: return 28; endcase
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_mode;
    bit m_hist[$];
    int m_cnt, m_wcnt, m_werr, m_gcnt, m_eacc, m_bacc, m_eres, m_bres;
    bit m_bad, m_inv, m_done;

    task automatic m_reset();
        m_hist = {};
        for (int i = 0; i < 31; i++) m_hist.push_back(1'b0);
        m_mode = 0; m_cnt = 0; m_bad = 0; m_inv = 0; m_wcnt = 0; m_werr = 0;
        m_gcnt = 0; m_eacc = 0; m_bacc = 0; m_eres = 0; m_bres = 0; m_done = 0;
    endtask

    task automatic m_step(input bit b);
        int  k = ord(prbs_sel);
        bit  p = m_hist[k-1] ^ m_hist[tap2(prbs_sel)-1];
        bit  fed = b;
        bit  e;
        if (m_mode == 0) begin
            m_cnt++;
            if (m_cnt == k) begin m_mode = 1; m_cnt = 0; end
        end else if (m_mode == 1) begin
            e = b ^ p;
            if (m_cnt == 0 || e == m_bad) begin
                m_cnt++; m_bad = e;
                if (m_cnt == 64) begin m_mode = 2; m_inv = e; m_cnt = 0; end
            end else begin
                m_cnt = 1; m_bad = e;
            end
        end else begin
            fed = p ^ m_inv;
            e = b ^ fed;
            m_bacc = (m_bacc + 1 > SAT) ? SAT : m_bacc + 1;
            m_eacc = (m_eacc + e > SAT) ? SAT : m_eacc + e;
            m_gcnt++;
            if (m_gcnt >= gate_len) begin
                m_eres = m_eacc; m_bres = m_bacc; m_done = 1;
                m_eacc = 0; m_bacc = 0; m_gcnt = 0;
            end
            if (m_werr + e > 16) begin
                m_mode = 0; m_cnt = 0; m_inv = 0; m_bad = 0; m_wcnt = 0; m_werr = 0;
            end else if (m_wcnt == 255) begin
                m_wcnt = 0; m_werr = 0;
            end else begin
                m_wcnt++; m_werr += e;
            end
        end
        m_hist.push_front(fed);
        void'(m_hist.pop_back());
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) m_reset();
        else begin
            m_done = 0;
            if (bit_valid) m_step(bit_in);
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(locked == (m_mode == 2), "R3 locked vs model", locked, m_mode == 2);
            check(inverted == m_inv, "R4 inverted vs model", inverted, m_inv);
            check(gate_done == m_done, "R7 gate_done vs model", gate_done, m_done);
            check(err_count == m_eres, "R5 err_count vs model", err_count, m_eres);
            check(bit_count == m_bres, "R8 bit_count vs model", bit_count, m_bres);
        end
    end

    // ---------------- stimulus ----------------
    bit g[$];

    task automatic gen_reset();
        g = {};
        for (int i = 0; i < 31; i++) g.push_back(1'b1);
    endtask

    function automatic bit gen_next();
        bit t = g[ord(prbs_sel)-1] ^ g[tap2(prbs_sel)-1];
        g.push_front(t);
        void'(g.pop_back());
        return t;
    endfunction

    task automatic do_reset(input int sel, input int glen);
        rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        prbs_sel = sel[1:0]; gate_len = glen[GATE_W-1:0];
        gen_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lock_at = -1;
    endtask

    // n valid bits; errors only on bits sent while locked
    task automatic stream(input int n, input bit inv, input int err_every,
                          input int err_max, input int gap_pct);
        int sent = 0;
        int lidx = 0;
        int ecnt = 0;
        bit b;
        while (sent < n) begin
            if (gap_pct > 0 && $urandom_range(99) < gap_pct) begin
                bit_valid = 1'b0; bit_in = 1'($urandom_range(1));
                @(negedge clk);
                continue;
            end
            b = gen_next() ^ inv;
            if (locked) begin
                if (err_every > 0 && (lidx % err_every) == err_every - 1 && ecnt < err_max) begin
                    b = ~b; ecnt++;
                end
                lidx++;
            end
            bit_valid = 1'b1; bit_in = b;
            @(negedge clk);
            sent++;
            if (locked && lock_at < 0) lock_at = sent;
        end
        bit_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(0, 200);
        @(negedge clk);
        check(!locked && !inverted && !gate_done, "R1 flags after reset", {locked, inverted, gate_done}, 0);
        check(err_count == 0 && bit_count == 0, "R1 results after reset", err_count + bit_count, 0);

        // R2 / R3 / R5: each order, clean stream
        for (int s = 0; s < 4; s++) begin
            do_reset(s, 200);
            stream(ord(s) + 64 + 205, 1'b0, 0, 0, 0);
            @(negedge clk);
            check(lock_at == ord(s) + 64, "R3 lock bit index", lock_at, ord(s) + 64);
            check(err_count == 0, "R2 clean stream errors", err_count, 0);
            check(bit_count == 200, "R5 only locked bits in gate", bit_count, 200);
            check(!inverted, "R4 true polarity flag", inverted, 0);
        end

        // R4 / R5: inverted stream with three injected errors
        do_reset(0, 100);
        stream(7 + 64 + 103, 1'b1, 10, 3, 0);
        @(negedge clk);
        check(inverted && locked, "R4 inverted lock", {locked, inverted}, 3);
        check(lock_at == 71, "R4 inverted lock index", lock_at, 71);
        check(err_count == 3, "R5 error count", err_count, 3);
        check(bit_count == 100, "R5 bit count", bit_count, 100);

        // R9: idle gaps carrying random data
        do_reset(1, 150);
        stream(15 + 64 + 152, 1'b0, 0, 0, 30);
        @(negedge clk);
        check(lock_at == 79, "R9 lock index with gaps", lock_at, 79);
        check(bit_count == 150 && err_count == 0, "R9 gate with gaps", bit_count, 150);

        // R6: sixteen errors kept, the seventeenth drops sync
        do_reset(0, 60000);
        stream(71, 1'b0, 0, 0, 0);
        check(locked, "R6 locked before burst", locked, 1);
        stream(16, 1'b0, 1, 16, 0);
        check(locked, "R6 sixteen errors tolerated", locked, 1);
        stream(1, 1'b0, 1, 1, 0);
        check(!locked && !inverted, "R6 seventeenth error drops", locked, 0);
        lock_at = -1;
        stream(71, 1'b0, 0, 0, 0);
        check(locked, "R6 reacquire after loss", locked, 1);

        // R8: saturation of both counters
        do_reset(0, 4800);
        stream(71 + 4802, 1'b0, 16, 100000, 0);
        @(negedge clk);
        check(locked, "R8 still locked at 16 per window", locked, 1);
        check(err_count == SAT, "R8 error count saturates", err_count, SAT);
        check(bit_count == SAT, "R8 bit count saturates", bit_count, SAT);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule